// File: doc/BRIEF.md
# Lock-Once Watchdog Timer with Keyed Service Sequence

This block is a supervisory timer that brings a stalled system back to a known state. Its clock is divided by a fixed prescaler of four, and the divided ticks step a 24-bit down-counter. Software stores a timeout constant, turns the timer on and then services it from time to time. A service is a key pair written to a service register. The first correct service after the timer is turned on starts the countdown. Each later correct service reloads the counter.

If the counter runs out, the timer fires. It also fires if a service sequence is malformed: the wrong first key, the wrong second key, or any other register access between the two keys. What happens on firing depends on a mode bit. The timer either sends a one-cycle reset request or raises an interrupt that stays high. In both cases it sets a sticky event flag and turns itself off. Once the timer is turned on, software cannot turn it off. Once it is counting, the mode is frozen as well. A debug-halt input stops the countdown while it is high.

The register port uses one address bus for writes and reads. Read data is a combinational decode of the address. The read strobe only marks that a read access took place, which matters while a service sequence is half done. The register port and the countdown run on the same clock.

Top module: `wdt_guard`

## Requirements
- R1: After reset the control register (address 0) reads 0, the timeout register (address 1) reads 0xFF, the count register (address 3) reads 0xFF, and both event outputs are low.
- R2: A valid service is a write of 0xAA to address 2, followed in the very next register access by a write of 0x55 to address 2. It is honoured only while the timer is on. It loads the counter from the timeout register and sets the running bit (control bit 3).
- R3: While running, the counter drops by one every 4 clocks. When the counter is already 0 on such a tick, the timer fires. After a service that loads L, the event appears exactly 4·(L+1) clocks later.
- R4: A timeout constant below 0xFF loads 0xFF into the counter. Values of 0xFF and above load unchanged.
- R5: With mode bit (control bit 1) at 1, firing gives a reset request that lasts exactly one clock. With it at 0, firing raises the interrupt, which stays high until the flag is cleared.
- R6: While the timer is on, any of the following fires at the edge of the offending access: a write to address 2 of a value other than 0xAA as a first key; any access after 0xAA other than a write of 0x55 to address 2.
- R7: The enable bit (control bit 0) is set by writing 1 and is not cleared by writing 0. Firing clears it. While the timer is running, writes cannot change the enable or mode bits.
- R8: Firing sets the event flag (control bit 2). The flag stays set until 1 is written to control bit 2, and that write also drops the interrupt.
- R9: While debug halt is high, the counter and prescaler hold their values. Counting resumes where it stopped.
- R10: While the timer is off, writes to address 2 have no effect: no event, and the control register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock, also the register port clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| regAddr | input | 2 | Register address: 0 control, 1 timeout, 2 service, 3 count |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe; counts as an access in the service sequence |
| wrData | input | 24 | Write data |
| rdData | output | 24 | Read data for regAddr (combinational) |
| debugHalt | input | 1 | Pauses the countdown while high |
| wdtRstReq | output | 1 | One-cycle reset request on firing in reset mode |
| wdtIrq | output | 1 | Interrupt level on firing in interrupt mode |

## Verification
Suppose the prescaler phase or the counter were wrong. The event would then come earlier or later than 4·(L+1) clocks after the service. It would show up as a request in the wrong cycle, and as a count readback that is off within the first four clocks after a reload. Suppose the service-sequence tracking or the lock bits were wrong. Then the control readback would show it, or a request would appear at the edge of the access itself rather than never. An interrupt that is not held, or a flag that is not sticky, shows on the next read of the control register.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TC   = 2'd1;
  localparam logic [1:0] ADDR_FEED = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;

  localparam int KEY_FIRST  = 'hAA;
  localparam int KEY_SECOND = 'h55;

  typedef struct packed {
    logic reload;
    logic run;
  } dp_cmd_t;
endpackage

// File: rtl/wdt_dp.sv
module wdt_dp
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int PRE_W    = 2,
  parameter int MIN_LOAD = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_cmd_t          cmd,
  input  logic [CNT_W-1:0] tcVal,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_LOAD);

  logic [CNT_W-1:0] loadVal;
  logic             tick;

  assign loadVal = (tcVal < FLOOR) ? FLOOR : tcVal;

  generate
    if (PRE_W == 0) begin : g_nopre
      assign tick = cmd.run;
    end else begin : g_pre
      localparam logic [PRE_W-1:0] PRE_LAST = '1;
      logic [PRE_W-1:0] pre;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          pre <= '0;
        else if (cmd.reload) pre <= '0;
        else if (cmd.run)    pre <= pre + 1'b1;
      end
      assign tick = cmd.run && (pre == PRE_LAST);
    end
  endgenerate

  assign expire = tick && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cnt <= FLOOR;
    else if (cmd.reload)        cnt <= loadVal;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int MIN_LOAD = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [CNT_W-1:0] wrData,
  input  logic             debugHalt,
  input  logic             expire,
  input  logic [CNT_W-1:0] cnt,
  output dp_cmd_t          cmd,
  output logic [CNT_W-1:0] tcVal,
  output logic [CNT_W-1:0] rdData,
  output logic             rstReq,
  output logic             irq,
  output logic             enable,
  output logic             flag,
  output logic             fire
);
  localparam logic [CNT_W-1:0] KEY_A = CNT_W'(KEY_FIRST);
  localparam logic [CNT_W-1:0] KEY_B = CNT_W'(KEY_SECOND);

  logic mode, running, armed, irqPend, rstPulse;
  logic access, feedWr, ctrlWr, goodFeed, badFeed;
  logic [CNT_W-1:0] tcReg;

  assign access = wrEn | rdEn;
  assign feedWr = wrEn && (regAddr == ADDR_FEED);
  assign ctrlWr = wrEn && (regAddr == ADDR_CTRL);

  always_comb begin
    goodFeed = 1'b0;
    badFeed  = 1'b0;
    if (enable) begin
      if (armed) begin
        if (access) begin
          if (feedWr && wrData == KEY_B) goodFeed = 1'b1;
          else                           badFeed  = 1'b1;
        end
      end else if (feedWr && wrData != KEY_A) begin
        badFeed = 1'b1;
      end
    end
  end

  assign fire       = badFeed | expire;
  assign cmd.reload = goodFeed;
  assign cmd.run    = running & ~debugHalt;
  assign tcVal      = tcReg;
  assign rstReq     = rstPulse;
  assign irq        = irqPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      mode     <= 1'b0;
      running  <= 1'b0;
      armed    <= 1'b0;
      flag     <= 1'b0;
      irqPend  <= 1'b0;
      rstPulse <= 1'b0;
      tcReg    <= CNT_W'(MIN_LOAD);
    end else begin
      rstPulse <= fire & mode;

      if (!enable)            armed <= 1'b0;
      else if (armed)         armed <= armed & ~access;
      else if (feedWr && wrData == KEY_A) armed <= 1'b1;

      if (goodFeed) running <= 1'b1;

      if (ctrlWr && !running) begin
        enable <= enable | wrData[0];
        mode   <= wrData[1];
      end
      if (ctrlWr && wrData[2]) begin
        flag    <= 1'b0;
        irqPend <= 1'b0;
      end
      if (wrEn && regAddr == ADDR_TC) tcReg <= wrData;

      if (fire) begin
        enable  <= 1'b0;
        running <= 1'b0;
        armed   <= 1'b0;
        flag    <= 1'b1;
        if (!mode) irqPend <= 1'b1;
      end
    end
  end

  always_comb begin
    rdData = '0;
    unique case (regAddr)
      ADDR_CTRL: rdData[3:0] = {running, flag, mode, enable};
      ADDR_TC:   rdData = tcReg;
      ADDR_FEED: rdData = '0;
      ADDR_CNT:  rdData = cnt;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int PRE_W    = 2,
  parameter int MIN_LOAD = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  input  logic             debugHalt,
  output logic             wdtRstReq,
  output logic             wdtIrq
);
  dp_cmd_t          dpCmd;
  logic [CNT_W-1:0] tcVal;
  logic [CNT_W-1:0] cnt;
  logic             expire;
  logic             enable;
  logic             flag;
  logic             fire;

  wdt_ctrl #(.CNT_W(CNT_W), .MIN_LOAD(MIN_LOAD)) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .debugHalt(debugHalt), .expire(expire), .cnt(cnt),
    .cmd(dpCmd), .tcVal(tcVal), .rdData(rdData), .rstReq(wdtRstReq),
    .irq(wdtIrq), .enable(enable), .flag(flag), .fire(fire)
  );

  wdt_dp #(.CNT_W(CNT_W), .PRE_W(PRE_W), .MIN_LOAD(MIN_LOAD)) uDp (
    .clk(clk), .rstN(rstN), .cmd(dpCmd), .tcVal(tcVal),
    .cnt(cnt), .expire(expire)
  );
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int CNT_W    = 24,
  parameter int MIN_LOAD = 255
) (
  input logic             clk,
  input logic             rstN,
  input logic             debugHalt,
  input logic             wdtRstReq,
  input logic             wdtIrq,
  input logic             reload,
  input logic             run,
  input logic             expire,
  input logic [CNT_W-1:0] cnt,
  input logic             enable,
  input logic             flag
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_LOAD);

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!reload && cnt != '0) |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - CNT_W'(1)));

  p_clamp_r4: assert property (@(posedge clk) disable iff (!rstN)
    reload |=> cnt >= FLOOR);

  p_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    wdtRstReq |=> !wdtRstReq);

  p_off_after_fire_r7: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (!enable && !run));

  p_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wdtRstReq || $rose(wdtIrq)) |-> flag);

  p_halt_r9: assert property (@(posedge clk) disable iff (!rstN)
    (debugHalt && !reload) |=> $stable(cnt));
endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W), .MIN_LOAD(MIN_LOAD)) uChk (
  .clk(clk), .rstN(rstN), .debugHalt(debugHalt), .wdtRstReq(wdtRstReq),
  .wdtIrq(wdtIrq), .reload(dpCmd.reload), .run(dpCmd.run), .expire(expire),
  .cnt(cnt), .enable(enable), .flag(flag)
);

// File: tb/sim_wdt_guard.sv
module sim_wdt_guard;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   regAddr = '0;
  logic         wrEn = 1'b0;
  logic         rdEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic         debugHalt = 1'b0;
  logic         wdtRstReq;
  logic         wdtIrq;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  wdt_guard u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .debugHalt(debugHalt),
    .wdtRstReq(wdtRstReq), .wdtIrq(wdtIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    regAddr = a; wrData = W'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdAccess(input logic [1:0] a);
    @(negedge clk);
    regAddr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    regAddr = a;
    #1 v = 32'(rdData);
  endtask

  task automatic feed();
    wr(2'd2, 'hAA);
    wr(2'd2, 'h55);
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int loads[6] = '{0, 'h40, 'hFE, 'hFF, 'h100, 'h1A3};
    waitN(5);
    rstN = 1'b1;
    waitN(2);

    // R1 reset state
    peek(2'd0, v); check("R1 ctrl", v, 0);
    peek(2'd1, v); check("R1 tc", v, 'hFF);
    peek(2'd3, v); check("R1 cnt", v, 'hFF);
    check("R1 rst", 32'(wdtRstReq), 0);
    check("R1 irq", 32'(wdtIrq), 0);

    // R10 service writes while off
    wr(2'd2, 'h12); check("R10 rst bad key off", 32'(wdtRstReq), 0);
    feed();         check("R10 rst feed off", 32'(wdtRstReq), 0);
    peek(2'd0, v);  check("R10 ctrl off", v, 0);

    // R7 enable not cleared by 0, mode writable before running
    wr(2'd0, 3); peek(2'd0, v); check("R7 enable set", v, 3);
    wr(2'd0, 0); peek(2'd0, v); check("R7 enable sticks", v, 1);
    wr(2'd0, 3);

    // R2 R3 R4 R5 R8 sweep of loads in reset mode
    foreach (loads[k]) begin
      int exp;
      exp = (loads[k] < 'hFF) ? 'hFF : loads[k];
      wr(2'd1, loads[k]);
      feed();
      peek(2'd3, v); check("R2 R4 reload value", v, exp);
      peek(2'd0, v); check("R2 running bit", v, 'hB);
      waitN(4);
      peek(2'd3, v); check("R3 first step", v, exp - 1);
      waitN(4 * (exp + 1) - 1 - 4);
      check("R3 no early event", 32'(wdtRstReq), 0);
      @(negedge clk);
      check("R3 R5 event on time", 32'(wdtRstReq), 1);
      peek(2'd0, v); check("R8 R7 flag set, off", v, 6);
      @(negedge clk);
      check("R5 single cycle", 32'(wdtRstReq), 0);
      check("R5 no irq in reset mode", 32'(wdtIrq), 0);
      wr(2'd0, 6); peek(2'd0, v); check("R8 flag cleared", v, 2);
      wr(2'd0, 3);
    end

    // R2 mid-run service reloads, R9 halt freezes
    wr(2'd1, 'h100);
    feed();
    waitN(100);
    peek(2'd3, v); check("R3 after 100 clocks", v, 'h100 - 25);
    feed();
    peek(2'd3, v); check("R2 service reloads", v, 'h100);
    waitN(10);
    debugHalt = 1'b1;
    peek(2'd3, v); check("R9 before halt", v, 'hFE);
    waitN(50);
    peek(2'd3, v); check("R9 frozen", v, 'hFE);
    check("R9 no event while halted", 32'(wdtRstReq), 0);
    debugHalt = 1'b0;
    waitN(4 * 257 - 10 - 1);
    check("R9 no early event", 32'(wdtRstReq), 0);
    @(negedge clk);
    check("R9 resumed event", 32'(wdtRstReq), 1);
    wr(2'd0, 4);

    // R5 interrupt mode holds until cleared
    wr(2'd0, 1);
    wr(2'd1, 0);
    feed();
    waitN(4 * 256 - 1);
    check("R5 irq not early", 32'(wdtIrq), 0);
    @(negedge clk);
    check("R5 irq raised", 32'(wdtIrq), 1);
    waitN(20);
    check("R5 irq held", 32'(wdtIrq), 1);
    check("R5 no reset in irq mode", 32'(wdtRstReq), 0);
    peek(2'd0, v); check("R8 flag irq mode", v, 4);
    wr(2'd0, 4);
    check("R8 irq cleared", 32'(wdtIrq), 0);
    peek(2'd0, v); check("R8 ctrl cleared", v, 0);

    // R7 lock while running
    wr(2'd0, 3);
    wr(2'd1, 'h300);
    feed();
    wr(2'd0, 0); peek(2'd0, v); check("R7 locked running", v, 'hB);
    wr(2'd0, 1); peek(2'd0, v); check("R7 mode locked", v, 'hB);

    // R6 malformed sequences
    wr(2'd2, 'h12);
    check("R6 wrong first key", 32'(wdtRstReq), 1);
    wr(2'd0, 6); wr(2'd0, 3);
    wr(2'd2, 'h55);
    check("R6 second key alone", 32'(wdtRstReq), 1);
    wr(2'd0, 6); wr(2'd0, 3);
    wr(2'd2, 'hAA);
    check("R6 no event after first key", 32'(wdtRstReq), 0);
    wr(2'd1, 5);
    check("R6 write between keys", 32'(wdtRstReq), 1);
    wr(2'd0, 6); wr(2'd0, 3);
    wr(2'd2, 'hAA);
    rdAccess(2'd3);
    check("R6 read between keys", 32'(wdtRstReq), 1);
    wr(2'd0, 6); wr(2'd0, 3);
    wr(2'd2, 'hAA);
    wr(2'd2, 'h54);
    check("R6 wrong second key", 32'(wdtRstReq), 1);
    peek(2'd0, v); check("R6 R8 flag after bad key", v, 6);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule